// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives a processor word-wide register access to the management registers of an Ethernet PHY. Software places write data in the data register, then writes the control register with a PHY register number and a read or write command bit. One cycle later the bridge performs the access and clears the command bit. For a read, the result appears in the upper half of the data register. Completion and PHY interrupt activity are collected in a small write-one-to-clear status register that drives a single enabled interrupt line.

So that the block can be tested on its own, a small PHY register set sits behind the bridge in place of a serial management link. It has control, status, identity, advertisement, partner ability, expansion, interrupt source and interrupt mask registers. It follows a `link_up` input, and autonegotiation completes the moment it is asked for. The serial clock/data bit timing and any real negotiation are not part of the block.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset the control, data, interrupt-status and interrupt-enable registers read zero and `irq` is low. In the first cycle after reset the PHY records the current `link_up` level as a link event.
- R2: Control register bit 27 requests a PHY write and bit 26 requests a PHY read, with the PHY register number in bits [25:21]. If both bits are set, the write is done. The access runs in the cycle after the control write, then both command bits clear and the other control bits keep their value.
- R3: A PHY write takes its value from data bits [15:0]. A PHY read puts the value in data bits [31:16] and leaves bits [15:0] unchanged.
- R4: After reset the PHY control register is 0x3000, status is 0x7809 (plus the link bits of R9), advertisement is 0x01E1, and the interrupt mask is 0.
- R5: PHY registers 2, 3, 5 and 6 read the constants 0x0007, 0xC0D1, 0x0F71 and 0x0001. Writes to them have no effect.
- R6: A write to PHY register 0 with bit 15 set restores every PHY register to its reset value, and the link level is then recorded again as an event. Any other write to register 0 stores the value ANDed with 0x7980, and if bit 12 of the value is set it also sets status bit 5.
- R7: A write to PHY register 4 stores (value AND 0x2D7F) OR 0x0080. A write to register 30 stores value bits [7:0] as the interrupt mask.
- R8: Reading PHY register 29 returns the interrupt source bits and clears them. A source bit set by a link event in the same cycle is kept.
- R9: Each change of `link_up` is handled once. On a rising edge, status bits 2 and 5 are set and source bits 7 and 6 are set. On a falling edge, status bits 2 and 5 are cleared and source bit 4 is set.
- R10: PHY register numbers other than 0–6, 29 and 30 read as zero. Writes to them, and to registers 1 and 29, change nothing.
- R11: In the interrupt status register, bit 0 is set when a PHY access completes and bit 1 is set while (source AND mask) is nonzero. Writing a one to a bit clears it, but a set in the same cycle wins. `irq` is high when any status bit is high and its enable bit is also set.
- R12: The bus word index selects the register: 0 is control, 1 is data, 2 is interrupt status, 3 is interrupt enable, and any other index reads zero. Read data is combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| link_up | input | 1 | PHY link level |
| irq | output | 1 | Enabled interrupt output |

## Verification
If the PHY state is wrong, it shows at the ports on the next management read of the affected register, two cycles after the command is written. If the interrupt-source path is wrong, it also shows up one cycle later as a changed interrupt status bit 1 and `irq`. A command bit that fails to clear, or read data that lands in the wrong half, can be seen on the data or control word in the cycle after the access. Because of this, the bench compares the selected read word and `irq` against its model after every clock edge, so a divergence is caught in the cycle it first becomes visible.

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          link_up,
  output logic          irq
);
  localparam int WRB = 27;
  localparam int RDB = 26;
  localparam logic [15:0] CTL_RST = 16'h3000;
  localparam logic [15:0] STS_RST = 16'h7809;
  localparam logic [15:0] ADV_RST = 16'h01E1;

  logic [31:0] ctrl_q, data_q;
  logic [1:0]  ien_q, ist_q;
  logic [15:0] p_ctl, p_sts, p_adv;
  logic [7:0]  p_msk, p_src;
  logic        link_q, seen_q;

  logic [4:0]  preg;
  logic        go_wr, go_rd, go, soft_rst, upd;
  logic [15:0] wval, rval;

  assign preg     = ctrl_q[25:21];
  assign go_wr    = ctrl_q[WRB];
  assign go_rd    = ctrl_q[RDB] & ~ctrl_q[WRB];
  assign go       = go_wr | go_rd;
  assign wval     = data_q[15:0];
  assign soft_rst = go_wr && preg == 5'd0 && wval[15];
  assign upd      = !seen_q || (link_up != link_q);

  always_comb begin
    case (preg)
      5'd0:    rval = p_ctl;
      5'd1:    rval = p_sts;
      5'd2:    rval = 16'h0007;
      5'd3:    rval = 16'hC0D1;
      5'd4:    rval = p_adv;
      5'd5:    rval = 16'h0F71;
      5'd6:    rval = 16'h0001;
      5'd29:   rval = {8'h00, p_src};
      5'd30:   rval = {8'h00, p_msk};
      default: rval = 16'h0000;
    endcase
  end

  // PHY register set
  logic [15:0] sts_n;
  logic [7:0]  src_n;
  always_comb begin
    sts_n = p_sts;
    if (go_wr && preg == 5'd0 && wval[12]) sts_n = sts_n | 16'h0020;
    if (upd) sts_n = link_up ? (sts_n | 16'h0024) : (sts_n & ~16'h0024);
    src_n = (go_rd && preg == 5'd29) ? 8'h00 : p_src;
    if (upd) src_n = src_n | (link_up ? 8'hC0 : 8'h10);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      p_ctl  <= CTL_RST;
      p_sts  <= STS_RST;
      p_adv  <= ADV_RST;
      p_msk  <= 8'h00;
      p_src  <= 8'h00;
      seen_q <= 1'b0;
      link_q <= link_up;
    end else begin
      seen_q <= 1'b1;
      link_q <= link_up;
      p_sts  <= sts_n;
      p_src  <= src_n;
      if (go_wr && preg == 5'd0)  p_ctl <= wval & 16'h7980;
      if (go_wr && preg == 5'd4)  p_adv <= (wval & 16'h2D7F) | 16'h0080;
      if (go_wr && preg == 5'd30) p_msk <= wval[7:0];
    end
  end

  // Bridge registers
  logic [1:0] ist_set, ist_clr;
  assign ist_set = {|(p_src & p_msk), go};
  assign ist_clr = (bus_wr && bus_addr == AW'(2)) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      ien_q  <= '0;
      ist_q  <= '0;
    end else begin
      if (go) ctrl_q[WRB:RDB] <= 2'b00;
      if (go_rd) data_q[31:16] <= rval;
      if (bus_wr && bus_addr == AW'(0)) ctrl_q <= bus_wdata;
      if (bus_wr && bus_addr == AW'(1)) data_q <= bus_wdata;
      if (bus_wr && bus_addr == AW'(3)) ien_q  <= bus_wdata[1:0];
      ist_q <= (ist_q & ~ist_clr) | ist_set;
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = ctrl_q;
      AW'(1):  bus_rdata = data_q;
      AW'(2):  bus_rdata = {30'd0, ist_q};
      AW'(3):  bus_rdata = {30'd0, ien_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(ist_q & ien_q);

  p_cmd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !(bus_wr && bus_addr == AW'(0))) |=> (ctrl_q[WRB:RDB] == 2'b00));
  p_done_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ist_q[0]);
  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b00) |-> !irq);
  p_link_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && link_up != link_q && !soft_rst) |=> (p_sts[2] == $past(link_up)));
  p_src_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_rd && preg == 5'd29 && !upd) |=> (p_src == 8'h00));
endmodule

// File: tb/mdio_reg_bridge_tb_top.sv
module mdio_reg_bridge_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        link_up = 0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  mdio_reg_bridge dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_up(link_up), .irq(irq));

  // behavioural reference model
  int m_ctrl, m_data, m_ien, m_ist, m_pc, m_ps, m_pa, m_pm, m_src;
  bit m_lq, m_seen;

  function automatic int m_phy_rd(int r);
    case (r)
      0: return m_pc;  1: return m_ps;  2: return 'h0007; 3: return 'hC0D1;
      4: return m_pa;  5: return 'h0F71; 6: return 1;
      29: return m_src; 30: return m_pm;
      default: return 0;
    endcase
  endfunction

  function automatic int m_rdata(int a);
    case (a)
      0: return m_ctrl; 1: return m_data; 2: return m_ist; 3: return m_ien;
      default: return 0;
    endcase
  endfunction

  task automatic m_step();
    int r, wv, nctrl, ndata, nien, nist, set, clr;
    bit wr, rd, upd;
    if (!rst_n) begin
      m_ctrl = 0; m_data = 0; m_ien = 0; m_ist = 0;
      m_pc = 'h3000; m_ps = 'h7809; m_pa = 'h01E1; m_pm = 0; m_src = 0;
      m_seen = 0; m_lq = link_up;
      return;
    end
    r = (m_ctrl >> 21) & 31;
    wr = m_ctrl[27];
    rd = m_ctrl[26] && !wr;
    wv = m_data & 'hFFFF;
    upd = !m_seen || (link_up != m_lq);
    nctrl = m_ctrl; ndata = m_data; nien = m_ien;
    set = ((m_src & m_pm) != 0 ? 2 : 0) | ((wr || rd) ? 1 : 0);
    clr = (bus_wr && bus_addr == 2) ? (bus_wdata & 3) : 0;
    if (wr || rd) nctrl = nctrl & ~(3 << 26);
    if (rd) ndata = (m_phy_rd(r) << 16) | (m_data & 'hFFFF);
    if (bus_wr && bus_addr == 0) nctrl = bus_wdata;
    if (bus_wr && bus_addr == 1) ndata = bus_wdata;
    if (bus_wr && bus_addr == 3) nien = bus_wdata & 3;
    nist = (m_ist & ~clr) | set;
    if (wr && r == 0 && wv[15]) begin
      m_pc = 'h3000; m_ps = 'h7809; m_pa = 'h01E1; m_pm = 0; m_src = 0;
      m_seen = 0;
    end else begin
      if (wr && r == 0) begin
        m_pc = wv & 'h7980;
        if (wv[12]) m_ps = m_ps | 'h20;
      end
      if (upd) m_ps = link_up ? (m_ps | 'h24) : (m_ps & ~'h24);
      if (rd && r == 29) m_src = 0;
      if (upd) m_src = m_src | (link_up ? 'hC0 : 'h10);
      if (wr && r == 4) m_pa = (wv & 'h2D7F) | 'h80;
      if (wr && r == 30) m_pm = wv & 'hFF;
      m_seen = 1;
    end
    m_lq = link_up;
    m_ctrl = nctrl; m_data = ndata; m_ien = nien; m_ist = nist;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    m_step();
    #1;
    cyc++;
    if (rst_n) begin
      chk("R12 model rdata", bus_rdata, m_rdata(bus_addr));
      chk("R11 model irq", int'(irq), ((m_ist & m_ien) != 0) ? 1 : 0);
    end
  end

  task automatic bwr(int a, int v);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[2:0]; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic brd(int a, string tag, int exp);
    @(negedge clk);
    bus_addr = a[2:0];
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic phy_wr(int r, int v);
    bwr(1, v);
    bwr(0, (1 << 27) | (r << 21));
  endtask

  task automatic phy_rd(int r, string tag, int exp);
    bwr(0, (1 << 26) | (r << 21));
    @(negedge clk);
    bus_addr = 1;
    #1;
    chk(tag, (bus_rdata >> 16) & 'hFFFF, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    brd(0, "R1 ctrl reset", 0);
    brd(1, "R1 data reset", 0);
    brd(2, "R1 istat reset", 0);
    brd(3, "R1 ien reset", 0);
    chk("R1 irq reset", int'(irq), 0);
    phy_rd(0, "R4 ctl reset", 'h3000);
    phy_rd(1, "R4 status reset", 'h7809);
    phy_rd(4, "R4 adv reset", 'h01E1);
    phy_rd(30, "R4 mask reset", 0);
    phy_rd(29, "R1 link-down event at reset", 'h0010);
    phy_rd(29, "R8 source cleared", 0);
    phy_rd(2, "R5 id1", 'h0007);
    phy_rd(3, "R5 id2", 'hC0D1);
    phy_rd(5, "R5 partner", 'h0F71);
    phy_rd(6, "R5 expansion", 1);
    phy_rd(7, "R10 unsupported 7", 0);
    phy_rd(31, "R10 unsupported 31", 0);
    // R3 low half kept on read
    bwr(1, 'h0000ABCD);
    phy_rd(3, "R3 read to upper half", 'hC0D1);
    brd(1, "R3 low half kept", 'hC0D1ABCD);
    // R2 command bits self clear, other bits kept
    bwr(0, (1 << 26) | (6 << 21) | 'h55);
    @(negedge clk);
    brd(0, "R2 cmd cleared", (6 << 21) | 'h55);
    brd(2, "R11 done flag", 1);
    bwr(2, 1);
    brd(2, "R11 w1c", 0);
    phy_wr(4, 'hFFFF);
    phy_rd(4, "R7 adv mask", 'h2DFF);
    phy_wr(30, 'h1234);
    phy_rd(30, "R7 mask low byte", 'h34);
    phy_wr(0, 'h7FFF);
    phy_rd(0, "R6 ctl masked", 'h7980);
    phy_rd(1, "R6 autoneg immediate", 'h7829);
    phy_wr(1, 0);
    phy_rd(1, "R10 status write ignored", 'h7829);
    phy_wr(5, 0);
    phy_rd(5, "R5 constant write ignored", 'h0F71);
    // R2 both bits: write wins
    bwr(1, 'h0001);
    bwr(0, (3 << 26) | (30 << 21));
    @(negedge clk);
    phy_rd(30, "R2 write priority", 1);
    // link up
    @(negedge clk); link_up = 1;
    repeat (3) @(negedge clk);
    phy_rd(1, "R9 link up status", 'h782D);
    phy_wr(30, 'h40);
    repeat (2) @(negedge clk);
    bwr(3, 2);
    brd(2, "R11 phy pending bit", 3);
    chk("R11 irq", int'(irq), 1);
    phy_rd(29, "R9 up sources", 'hC0);
    phy_rd(29, "R8 read clears", 0);
    bwr(2, 3);
    @(negedge clk);
    brd(2, "R11 cleared", 0);
    chk("R11 irq low", int'(irq), 0);
    // R8 event in same cycle as clearing read
    bwr(0, (1 << 26) | (29 << 21));
    link_up = 0;
    @(negedge clk);
    phy_rd(29, "R8 same-cycle event kept", 'h10);
    phy_rd(1, "R9 link down status", 'h7809);
    // R6 soft reset
    phy_wr(4, 0);
    phy_wr(0, 'h8000);
    repeat (2) @(negedge clk);
    phy_rd(4, "R6 soft reset adv", 'h01E1);
    phy_rd(0, "R6 soft reset ctl", 'h3000);
    phy_rd(29, "R6 link re-recorded", 'h10);
    brd(5, "R12 unmapped index", 0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule